// File: doc/BRIEF.md
# Dual-Bank Card Receive Data Buffer

This block takes the byte stream produced by a memory-card data line deserializer and stores it in two 8-byte banks that are used in turn. Bytes fill bank A first and then bank B. A full bank is handed to the host, and the writer moves on to the other bank. The host empties the bank it holds by popping bytes through one data port. When the last byte is popped, the bank goes back to the writer.

Each bank has a sticky full flag and a mask bit, and the flags combine into an interrupt request. In polling mode the host masks both banks and watches the flags directly. A block shorter than one bank ends with an end-of-frame strobe. That strobe closes the partly filled bank, and the bank then holds only the bytes that were received. A receive timeout is armed by a start strobe and expires after a programmable number of cycles. It is cancelled by the first full bank or by end-of-frame. A level-sensitive controller reset returns all state to idle.

Top module: `card_rx_buffer`

## Requirements
- R1: After reset every flag, the interrupt and `rd_data` are 0.
- R2: Accepted bytes fill bank A in arrival order and then bank B, alternating from then on. `full_a` (bank A) or `full_b` (bank B) rises on the clock edge that stores the 8th byte of that bank.
- R3: While the host holds a bank, `rd_data` shows that bank's oldest unread byte and each `rd_en` pulse moves it on by one byte. After the last byte is popped, that bank's full flag clears, the bank returns to the writer, and the other bank is read next. While no bank is held, `rd_data` is 0 and `rd_en` has no effect.
- R4: `irq` = (`full_a` AND NOT `mask_a`) OR (`full_b` AND NOT `mask_b`) OR `eof_flag`. A mask value of 1 blocks that bank's flag from the interrupt.
- R5: With `blk_len` below 8, an `in_eof` strobe closes the current bank if it holds 1 to 7 bytes. The host then holds that bank and drains it in exactly that many pops. No full flag is raised.
- R6: Every `in_eof` strobe sets `eof_flag`. The flag stays set until a status read.
- R7: A `stat_rd` pulse clears `full_a`, `full_b`, `eof_flag`, `ovr_flag` and `tmo_flag`, but a flag set in the same cycle wins over the clear. Bank ownership and the data are unchanged.
- R8: A byte that arrives while both banks are held by the host is dropped and sets `ovr_flag`.
- R9: `rx_start` arms the timeout, and `rx_start` while already armed restarts it. `tmo_flag` rises on the edge `tmo_limit` cycles after the arming edge, unless a bank becomes full or `in_eof` occurs first. `tmo_limit` must be at least 1.
- R10: While `dc_reset` is 1, every flag and both banks are cleared and pointers return to bank A slot 0. After `dc_reset` goes back to 0, the next byte is stored in bank A first.
- R11: With `blk_len` of 8 or more, `in_eof` sets only `eof_flag` and does not close a partly filled bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the deserializer |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | End-of-frame strobe |
| blk_len | input | 4 | Configured block length in bytes |
| rx_start | input | 1 | Arms the receive timeout |
| tmo_limit | input | 16 | Timeout length in cycles (nonzero) |
| rd_en | input | 1 | Host pop from the held bank |
| rd_data | output | 8 | Byte at the head of the held bank |
| stat_rd | input | 1 | Host status read, clears sticky flags |
| mask_a | input | 1 | 1 blocks `full_a` from `irq` |
| mask_b | input | 1 | 1 blocks `full_b` from `irq` |
| dc_reset | input | 1 | Controller reset bit, level sensitive |
| full_a | output | 1 | Bank A full flag |
| full_b | output | 1 | Bank B full flag |
| eof_flag | output | 1 | End-of-frame flag |
| ovr_flag | output | 1 | Overrun flag |
| tmo_flag | output | 1 | Receive timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The timeout checks assume that `tmo_limit` is nonzero and does not change while the counter is armed. The stimulus sets it to 12 once before reset is released and never changes it. The bank checks assume no particular timing between the writer and the host. For that reason the random phase mixes bytes, pops, end-of-frame strobes, status reads and controller resets freely, and it runs into overruns and same-cycle set/clear conflicts on purpose.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef logic [NUM_BANKS-1:0] bank_vec_t;
endpackage

// File: rtl/card_rx_banks.sv
module card_rx_banks
  import card_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dc_reset,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output bank_vec_t         full_set,
  output bank_vec_t         drain_done,
  output logic              ovr_set
);

  logic [DATA_W-1:0] mem_q [NUM_BANKS][DEPTH];
  logic              wb_q, wb_d, rb_q, rb_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d, rcnt_q, rcnt_d, wcnt_post;
  logic [CNT_W-1:0]  fill_q [NUM_BANKS];
  logic [CNT_W-1:0]  fill_d [NUM_BANKS];
  bank_vec_t         own_q, own_d;
  logic              active, wr_ok, wr_close, eof_close, bank_close, rd_ok, rd_last;

  // decode of this cycle's events
  always_comb begin
    active     = !dc_reset;
    wr_ok      = active && in_valid && !own_q[wb_q];
    ovr_set    = active && in_valid && own_q[wb_q];
    wcnt_post  = wcnt_q + CNT_W'(wr_ok);
    wr_close   = wr_ok && (wcnt_q == CNT_W'(DEPTH - 1));
    eof_close  = active && in_eof && (blk_len < CNT_W'(DEPTH)) &&
                 !wr_close && (wcnt_post != '0);
    bank_close = wr_close || eof_close;
    rd_ok      = active && rd_en && own_q[rb_q];
    rd_last    = rd_ok && (rcnt_q == fill_q[rb_q] - CNT_W'(1));
  end

  // next state
  always_comb begin
    wb_d   = wb_q;
    rb_d   = rb_q;
    wcnt_d = wcnt_q;
    rcnt_d = rcnt_q;
    own_d  = own_q;
    for (int b = 0; b < NUM_BANKS; b++) fill_d[b] = fill_q[b];
    if (!active) begin
      wb_d   = 1'b0;
      rb_d   = 1'b0;
      wcnt_d = '0;
      rcnt_d = '0;
      own_d  = '0;
      for (int b = 0; b < NUM_BANKS; b++) fill_d[b] = '0;
    end else begin
      wcnt_d = wcnt_post;
      if (bank_close) begin
        own_d[wb_q]  = 1'b1;
        fill_d[wb_q] = wr_close ? CNT_W'(DEPTH) : wcnt_post;
        wb_d         = !wb_q;
        wcnt_d       = '0;
      end
      if (rd_ok) begin
        rcnt_d = rcnt_q + CNT_W'(1);
        if (rd_last) begin
          rcnt_d      = '0;
          own_d[rb_q] = 1'b0;
          rb_d        = !rb_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q   <= 1'b0;
      rb_q   <= 1'b0;
      wcnt_q <= '0;
      rcnt_q <= '0;
      own_q  <= '0;
      for (int b = 0; b < NUM_BANKS; b++) fill_q[b] <= '0;
    end else begin
      wb_q   <= wb_d;
      rb_q   <= rb_d;
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
      own_q  <= own_d;
      for (int b = 0; b < NUM_BANKS; b++) fill_q[b] <= fill_d[b];
    end
  end

  // storage, written only with the write enable
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wb_q][wcnt_q[PTR_W-1:0]] <= in_data;
  end

  assign rd_data = own_q[rb_q] ? mem_q[rb_q][rcnt_q[PTR_W-1:0]] : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_evt
    assign full_set[b]   = wr_close && (wb_q == 1'(b));
    assign drain_done[b] = rd_last && (rb_q == 1'(b));
  end

  // R8
  ovr_both_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |-> (own_q == '1));

  // R3
  rd_ptr_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_q[rb_q] |-> (rcnt_q < fill_q[rb_q]));

  // R2
  wr_ptr_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q < CNT_W'(DEPTH));

endmodule

// File: rtl/card_rx_flags.sv
module card_rx_flags
  import card_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dc_reset,
  input  bank_vec_t full_set,
  input  bank_vec_t drain_done,
  input  logic      eof_in,
  input  logic      ovr_set,
  input  logic      tmo_set,
  input  logic      stat_rd,
  input  bank_vec_t mask,
  output bank_vec_t full,
  output logic      eof_flag,
  output logic      ovr_flag,
  output logic      tmo_flag,
  output logic      irq
);

  bank_vec_t full_q, full_d;
  logic      eof_q, eof_d, ovr_q, ovr_d, tmo_q, tmo_d;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      full_d[b] = !dc_reset &&
                  (full_set[b] || (full_q[b] && !stat_rd && !drain_done[b]));
    end
    eof_d = !dc_reset && (eof_in  || (eof_q && !stat_rd));
    ovr_d = !dc_reset && (ovr_set || (ovr_q && !stat_rd));
    tmo_d = !dc_reset && (tmo_set || (tmo_q && !stat_rd));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      eof_q  <= 1'b0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      eof_q  <= eof_d;
      ovr_q  <= ovr_d;
      tmo_q  <= tmo_d;
    end
  end

  assign full     = full_q;
  assign eof_flag = eof_q;
  assign ovr_flag = ovr_q;
  assign tmo_flag = tmo_q;
  assign irq      = (|(full_q & ~mask)) || eof_q;

  // R3
  drain_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done[0] && !full_set[0]) |=> !full_q[0]);

  // R7
  status_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (full_set == '0) && !eof_in && !ovr_set && !tmo_set)
      |=> (full_q == '0) && !eof_q && !ovr_q && !tmo_q);

endmodule

// File: rtl/card_rx_timeout.sv
module card_rx_timeout #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dc_reset,
  input  logic             rx_start,
  input  logic             disarm,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_set
);

  logic             armed_q, armed_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    tmo_set = 1'b0;
    if (dc_reset) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (rx_start) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (disarm) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else if (cnt_q + TMO_W'(1) == limit) begin
        tmo_set = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + TMO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9
  expiry_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_set |=> !armed_q);

  // R9
  count_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < limit));

endmodule

// File: rtl/card_rx_buffer.sv
module card_rx_buffer
  import card_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TMO_W  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic              rx_start,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_rd,
  input  logic              mask_a,
  input  logic              mask_b,
  input  logic              dc_reset,
  output logic              full_a,
  output logic              full_b,
  output logic              eof_flag,
  output logic              ovr_flag,
  output logic              tmo_flag,
  output logic              irq
);

  bank_vec_t full_set, drain_done, full_vec;
  logic      ovr_set, tmo_set;

  card_rx_banks #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .dc_reset   (dc_reset),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_eof     (in_eof),
    .blk_len    (blk_len),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .full_set   (full_set),
    .drain_done (drain_done),
    .ovr_set    (ovr_set)
  );

  card_rx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .dc_reset   (dc_reset),
    .full_set   (full_set),
    .drain_done (drain_done),
    .eof_in     (in_eof),
    .ovr_set    (ovr_set),
    .tmo_set    (tmo_set),
    .stat_rd    (stat_rd),
    .mask       ({mask_b, mask_a}),
    .full       (full_vec),
    .eof_flag   (eof_flag),
    .ovr_flag   (ovr_flag),
    .tmo_flag   (tmo_flag),
    .irq        (irq)
  );

  card_rx_timeout #(.TMO_W(TMO_W)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .dc_reset (dc_reset),
    .rx_start (rx_start),
    .disarm   ((|full_set) || in_eof),
    .limit    (tmo_limit),
    .tmo_set  (tmo_set)
  );

  assign full_a = full_vec[0];
  assign full_b = full_vec[1];

  // R10
  ctrl_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_reset |=> !full_a && !full_b && !eof_flag && !ovr_flag && !tmo_flag &&
                 (rd_data == '0));

endmodule

// File: tb/test_card_rx_buffer.sv
module test_card_rx_buffer;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_eof = 1'b0, rx_start = 1'b0, rd_en = 1'b0;
  logic       stat_rd = 1'b0, mask_a = 1'b0, mask_b = 1'b0, dc_reset = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [3:0] blk_len = 4'd8;
  logic [15:0] tmo_limit = 16'd12;
  logic [7:0] rd_data;
  logic       full_a, full_b, eof_flag, ovr_flag, tmo_flag, irq;

  card_rx_buffer i_card_rx_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eof(in_eof), .blk_len(blk_len), .rx_start(rx_start),
    .tmo_limit(tmo_limit), .rd_en(rd_en), .rd_data(rd_data),
    .stat_rd(stat_rd), .mask_a(mask_a), .mask_b(mask_b),
    .dc_reset(dc_reset), .full_a(full_a), .full_b(full_b),
    .eof_flag(eof_flag), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // behavioural reference model
  logic [7:0] wq[$], hq0[$], hq1[$];
  bit held0, held1, m_fa, m_fb, m_eof, m_ovr, m_tmo, m_arm;
  int wbk, rbk, m_cnt;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    wq.delete(); hq0.delete(); hq1.delete();
    held0 = 0; held1 = 0; wbk = 0; rbk = 0;
    m_fa = 0; m_fb = 0; m_eof = 0; m_ovr = 0; m_tmo = 0; m_arm = 0; m_cnt = 0;
  endtask

  task automatic model_close(output bit closed_b);
    if (wbk == 0) begin hq0 = wq; held0 = 1; end
    else          begin hq1 = wq; held1 = 1; end
    closed_b = (wbk == 1);
    wq.delete();
    wbk = 1 - wbk;
  endtask

  task automatic model_step();
    bit hp0 = held0, hp1 = held1;
    bit fs0 = 0, fs1 = 0, dr0 = 0, dr1 = 0, ovs = 0, tms = 0, cb;
    if (dc_reset) begin
      model_clear();
      return;
    end
    if (rd_en) begin
      if (rbk == 0 && held0) begin
        void'(hq0.pop_front());
        if (hq0.size() == 0) begin held0 = 0; dr0 = 1; rbk = 1; end
      end else if (rbk == 1 && held1) begin
        void'(hq1.pop_front());
        if (hq1.size() == 0) begin held1 = 0; dr1 = 1; rbk = 0; end
      end
    end
    if (in_valid) begin
      if ((wbk == 0) ? hp0 : hp1) ovs = 1;
      else begin
        wq.push_back(in_data);
        if (wq.size() == DEPTH) begin
          model_close(cb);
          if (cb) fs1 = 1; else fs0 = 1;
        end
      end
    end
    if (in_eof && blk_len < DEPTH && wq.size() > 0) model_close(cb);
    if (rx_start) begin
      m_arm = 1; m_cnt = 0;
    end else if (m_arm) begin
      if (fs0 || fs1 || in_eof) m_arm = 0;
      else begin
        m_cnt++;
        if (m_cnt == int'(tmo_limit)) begin tms = 1; m_arm = 0; end
      end
    end
    m_fa  = fs0 || (m_fa && !stat_rd && !dr0);
    m_fb  = fs1 || (m_fb && !stat_rd && !dr1);
    m_eof = in_eof || (m_eof && !stat_rd);
    m_ovr = ovs || (m_ovr && !stat_rd);
    m_tmo = tms || (m_tmo && !stat_rd);
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    exp_rd = (rbk == 0) ? (held0 ? hq0[0] : 8'h00) : (held1 ? hq1[0] : 8'h00);
    chk("R3", "rd_data", rd_data, exp_rd);
    chk("R2", "full_a", full_a, m_fa);
    chk("R2", "full_b", full_b, m_fb);
    chk("R6", "eof_flag", eof_flag, m_eof);
    chk("R8", "ovr_flag", ovr_flag, m_ovr);
    chk("R9", "tmo_flag", tmo_flag, m_tmo);
    chk("R4", "irq", irq, (m_fa && !mask_a) || (m_fb && !mask_b) || m_eof);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (rst_n) begin
      model_step();
      compare();
    end
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1; in_data = d; cyc(); in_valid = 0;
  endtask

  task automatic pop();
    rd_en = 1; cyc(); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic status_read();
    stat_rd = 1; cyc(); stat_rd = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "flags", {full_a, full_b, eof_flag, ovr_flag, tmo_flag, irq}, 0);
    chk("R1", "rd_data", rd_data, 8'h00);
    rst_n = 1;
    cyc();

    // R2 / R3 fill both banks and drain them
    rx_start = 1; cyc(); rx_start = 0;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    chk("R2", "full_a after 8 bytes", {full_a, full_b}, 2'b10);
    chk("R3", "head of bank A", rd_data, 8'h10);
    for (int i = 0; i < 8; i++) push(8'h20 + 8'(i));
    chk("R2", "full_b after 16 bytes", full_b, 1);
    for (int i = 0; i < 8; i++) pop();
    chk("R3", "full_a cleared by drain", full_a, 0);
    chk("R3", "bank B read next", rd_data, 8'h20);
    for (int i = 0; i < 8; i++) pop();
    chk("R3", "no bank held", rd_data, 8'h00);
    pop();
    chk("R3", "pop with no bank ignored", rd_data, 8'h00);
    idle(14);
    chk("R9", "timeout disarmed by full", tmo_flag, 0);

    // R8 overrun
    for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
    push(8'h99);
    chk("R8", "ovr_flag", ovr_flag, 1);
    for (int i = 0; i < 8; i++) pop();
    chk("R8", "bank B intact", rd_data, 8'h38);
    for (int i = 0; i < 8; i++) pop();
    chk("R8", "dropped byte absent", rd_data, 8'h00);
    status_read();
    chk("R7", "ovr cleared", ovr_flag, 0);

    // R7 status read keeps the bank
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    status_read();
    chk("R7", "full_a cleared by status", full_a, 0);
    chk("R7", "bank still held", rd_data, 8'h40);
    for (int i = 0; i < 8; i++) pop();

    // R9 expiry and disarm by end-of-frame
    rx_start = 1; cyc(); rx_start = 0;
    idle(11);
    chk("R9", "not yet expired", tmo_flag, 0);
    idle(1);
    chk("R9", "expired at limit", tmo_flag, 1);
    status_read();
    rx_start = 1; cyc(); rx_start = 0;
    idle(3);
    in_eof = 1; cyc(); in_eof = 0;
    idle(15);
    chk("R9", "disarmed by eof", tmo_flag, 0);
    chk("R6", "eof sticky", eof_flag, 1);
    status_read();
    chk("R6", "eof cleared by status", eof_flag, 0);

    // R5 short block
    blk_len = 4'd2;
    push(8'h50); push(8'h51);
    in_eof = 1; cyc(); in_eof = 0;
    chk("R5", "eof flag", eof_flag, 1);
    chk("R5", "no full flag", {full_a, full_b}, 2'b00);
    chk("R5", "short bank head", rd_data, 8'h50);
    pop();
    chk("R5", "second byte", rd_data, 8'h51);
    pop();
    chk("R5", "drained after 2", rd_data, 8'h00);
    status_read();

    // R11 long block: eof does not close
    blk_len = 4'd8;
    for (int i = 0; i < 3; i++) push(8'h60 + 8'(i));
    in_eof = 1; cyc(); in_eof = 0;
    chk("R11", "partial bank not closed", rd_data, 8'h00);
    for (int i = 3; i < 8; i++) push(8'h60 + 8'(i));
    chk("R11", "bank A full", full_a, 1);
    chk("R11", "head after eof", rd_data, 8'h60);
    for (int i = 0; i < 8; i++) pop();
    status_read();

    // R4 masks
    mask_a = 1; mask_b = 1;
    for (int i = 0; i < 8; i++) push(8'h80 + 8'(i));
    chk("R4", "masked full_b", {full_b, irq}, 2'b10);
    mask_b = 0; cyc();
    chk("R4", "unmasked full_b", irq, 1);
    for (int i = 0; i < 8; i++) pop();
    mask_a = 0;

    // R10 controller reset
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
    dc_reset = 1; cyc(); dc_reset = 0; cyc();
    chk("R10", "flags idle", {full_a, full_b, eof_flag, ovr_flag, tmo_flag}, 0);
    for (int i = 0; i < 8; i++) push(8'h70 + 8'(i));
    chk("R10", "bank A refilled", full_a, 1);
    chk("R10", "slot 0 first", rd_data, 8'h70);
    for (int i = 0; i < 8; i++) pop();

    // mixed random traffic checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      in_valid = ($urandom % 2) == 0;
      in_data  = 8'($urandom);
      rd_en    = ($urandom % 3) != 0;
      stat_rd  = ($urandom % 16) == 0;
      in_eof   = ($urandom % 40) == 0;
      rx_start = ($urandom % 60) == 0;
      dc_reset = ($urandom % 150) == 0;
      blk_len  = (($urandom % 2) == 0) ? 4'd2 : 4'd8;
      if (i % 50 == 0) begin
        mask_a = ($urandom % 2) == 0;
        mask_b = ($urandom % 2) == 0;
      end
      cyc();
    end
    in_valid = 0; rd_en = 0; stat_rd = 0; in_eof = 0; rx_start = 0; dc_reset = 0;
    idle(4);
    finish_run();
  end
endmodule